// File: doc/BRIEF.md
# Host Controller Command and Interrupt Status Registers

This block holds the command/status word and the interrupt bookkeeping of an embedded bus host controller. Host software reaches it through a command-code port: an 8-bit code picks the register and the direction, a 32-bit word carries write data, and read and write strobes qualify each access. Read data comes back registered, in the cycle after the read strobe.

The command/status word has two live fields. The first is a software reset bit. Software sets it, and it stays set until the controller core reports that the reset has finished. The second is a two-bit counter of scheduling overruns. The controller core reports events on a vector of pulse inputs. Each event latches its own bit in the interrupt status register, and only software can clear those bits, by writing ones. One interrupt output combines the status bits, a per-bit enable register and a master enable.

While the reset bit is set, the block drives a request to the core. It also holds the operational registers at zero, so that the controller comes back from reset quiet, in its suspend state.

Top module: `hc_cmd_irq_regs`

## Requirements
- R1: After reset, every register reads 0, `irq` is 0, `rst_req` is 0 and `rd_data` is 0.
- R2: A read strobe with code 02h returns the command/status word in the next cycle. The reset bit sits at bit 0, the overrun counter at bits 17:16, and all other bits read 0.
- R3: Each cycle in which `evt[0]` (scheduling overrun) is high adds one to the overrun counter. The counter wraps from 3 to 0 and does not saturate. It holds its value in cycles without that event.
- R4: The overrun counter still counts when status bit 0 is already set.
- R5: A write with code 82h and data bit 0 = 1 sets the reset bit, which drives `rst_req`. A write of 0 does not clear it. It clears only in the cycle after `rst_done` is sampled high while it is set, and `rst_done` has no effect while it is clear.
- R6: The clock edge that sets the reset bit clears the status register, the enable register, the master enable and the overrun counter. While the bit stays set, events and enable writes are ignored, so these registers read 0.
- R7: A high `evt[i]` sets interrupt status bit i. The status register is read with code 03h, with bits above NEVT-1 reading 0.
- R8: A write with code 83h clears each status bit whose data bit is 1, and leaves a bit alone where the data bit is 0. No write can set a status bit.
- R9: If an event and a clear hit the same status bit in the same cycle, the bit ends up set.
- R10: The enable register is written with code 84h and read with code 04h. It holds the per-bit enables in bits NEVT-1:0 and the master enable in bit 31. `irq` is high exactly when the master enable is 1 and at least one status bit is set together with its enable.
- R11: Reads with any other code return 0, and writes with any other code change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_code | input | 8 | Register command code |
| wr_data | input | 32 | Write data |
| wr_stb | input | 1 | Write strobe |
| rd_stb | input | 1 | Read strobe |
| rd_data | output | 32 | Read data, registered |
| evt | input | NEVT | Event pulses from the core; bit 0 is scheduling overrun |
| rst_done | input | 1 | Core reports that the software reset has finished |
| rst_req | output | 1 | Software reset request to the core |
| irq | output | 1 | Interrupt output |

## Verification
The bench drives four overrun pulses, with the status bit already set after the first. A counter that saturated, or that stopped counting once the flag was up, would read 3 or 1 where the bench expects 0.

It also clears a status bit in the same cycle that an event sets it, and clears one bit while another is being set. A design that let the clear win would lose the event, and a design that cleared whole words would wipe the neighbouring bit.

The reset tests write 0 to the reset bit and fire events and enable writes during reset. A design whose reset bit is cleared by software, or that let registers fill while reset is pending, would show a dropped `rst_req` or nonzero reads. Finally, enables are switched with and without the master bit, so an interrupt that ignored either gate would be seen.

// File: rtl/hc_cmd_irq_regs.sv
module hc_cmd_irq_regs #(
  parameter int NEVT = 7,
  parameter logic [7:0] CODE_CS_RD = 8'h02,
  parameter logic [7:0] CODE_CS_WR = 8'h82,
  parameter logic [7:0] CODE_IS_RD = 8'h03,
  parameter logic [7:0] CODE_IS_WR = 8'h83,
  parameter logic [7:0] CODE_IE_RD = 8'h04,
  parameter logic [7:0] CODE_IE_WR = 8'h84
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [7:0]      cmd_code,
  input  logic [31:0]     wr_data,
  input  logic            wr_stb,
  input  logic            rd_stb,
  output logic [31:0]     rd_data,
  input  logic [NEVT-1:0] evt,
  input  logic            rst_done,
  output logic            rst_req,
  output logic            irq
);
  localparam int MIE_BIT = 31;
  localparam int SOC_LSB = 16;

  logic            hcr;
  logic [1:0]      soc;
  logic [NEVT-1:0] ists;
  logic [NEVT-1:0] ien;
  logic            mie;
  logic [31:0]     rd_mux;

  wire wr_cs    = wr_stb && (cmd_code == CODE_CS_WR);
  wire wr_is    = wr_stb && (cmd_code == CODE_IS_WR);
  wire wr_ie    = wr_stb && (cmd_code == CODE_IE_WR);
  wire hcr_set  = !hcr && wr_cs && wr_data[0];
  wire in_reset = hcr || hcr_set;

  wire [NEVT-1:0] clr_mask = wr_is ? wr_data[NEVT-1:0] : '0;

  logic unused_wr_bits;
  assign unused_wr_bits = ^wr_data[MIE_BIT-1:NEVT];

  assign rst_req = hcr;
  assign irq     = mie && |(ists & ien);

  always_comb begin
    rd_mux = '0;
    case (cmd_code)
      CODE_CS_RD: begin
        rd_mux[0]                 = hcr;
        rd_mux[SOC_LSB+1:SOC_LSB] = soc;
      end
      CODE_IS_RD: rd_mux[NEVT-1:0] = ists;
      CODE_IE_RD: begin
        rd_mux[NEVT-1:0] = ien;
        rd_mux[MIE_BIT]  = mie;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hcr     <= 1'b0;
      soc     <= 2'b00;
      ists    <= '0;
      ien     <= '0;
      mie     <= 1'b0;
      rd_data <= '0;
    end else begin
      if (hcr) begin
        if (rst_done) hcr <= 1'b0;
      end else if (hcr_set) begin
        hcr <= 1'b1;
      end

      if (in_reset) begin
        soc  <= 2'b00;
        ists <= '0;
        ien  <= '0;
        mie  <= 1'b0;
      end else begin
        if (evt[0]) soc <= soc + 2'd1;
        ists <= (ists & ~clr_mask) | evt;
        if (wr_ie) begin
          ien <= wr_data[NEVT-1:0];
          mie <= wr_data[MIE_BIT];
        end
      end

      if (rd_stb) rd_data <= rd_mux;
    end
  end
endmodule

// File: rtl/hc_cmd_irq_regs_chk.sv
module hc_cmd_irq_regs_chk #(
  parameter int NEVT = 7,
  parameter logic [7:0] CODE_CS_WR = 8'h82,
  parameter int RST_LIMIT = 500
) (
  input logic            clk,
  input logic            rst_n,
  input logic [7:0]      cmd_code,
  input logic [31:0]     wr_data,
  input logic            wr_stb,
  input logic [NEVT-1:0] evt,
  input logic            rst_done,
  input logic            rst_req,
  input logic            irq,
  input logic [1:0]      soc,
  input logic [NEVT-1:0] ists,
  input logic [NEVT-1:0] ien,
  input logic            mie
);
  wire set_now = !rst_req && wr_stb && (cmd_code == CODE_CS_WR) && wr_data[0];
  wire active  = !rst_req && !set_now;

  int unsigned rst_cycles;
  always_ff @(posedge clk) begin
    if (!rst_n || !rst_req) rst_cycles <= 0;
    else rst_cycles <= rst_cycles + 1;
  end

  AST_SOC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (active && evt[0]) |=> (soc == 2'($past(soc) + 2'd1))); // R4
  AST_SOC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !evt[0]) |=> $stable(soc)); // R3
  AST_RST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req && !rst_done) |=> rst_req); // R5
  AST_RST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req && rst_done) |=> !rst_req); // R5
  AST_RST_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    rst_cycles < RST_LIMIT); // R5
  AST_RST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (ists == '0 && ien == '0 && !mie && soc == 2'b00 && !irq)); // R6
  AST_EVT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    active |=> ((ists & $past(evt)) == $past(evt))); // R9
  AST_NO_SW_SET: assert property (@(posedge clk) disable iff (!rst_n)
    active |=> ((ists & ~$past(ists) & ~$past(evt)) == '0)); // R8
  AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mie && (ists & ien) != '0)); // R10
endmodule

bind hc_cmd_irq_regs hc_cmd_irq_regs_chk #(.NEVT(NEVT), .CODE_CS_WR(CODE_CS_WR)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_code(cmd_code), .wr_data(wr_data), .wr_stb(wr_stb),
  .evt(evt), .rst_done(rst_done), .rst_req(rst_req), .irq(irq),
  .soc(soc), .ists(ists), .ien(ien), .mie(mie)
);

// File: tb/tb_hc_cmd_irq_regs.sv
module tb_hc_cmd_irq_regs;
  localparam int NEVT = 7;
  localparam time CLK_HALF = 10ns;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [7:0]      cmd_code = '0;
  logic [31:0]     wr_data = '0;
  logic            wr_stb = 1'b0;
  logic            rd_stb = 1'b0;
  logic [31:0]     rd_data;
  logic [NEVT-1:0] evt = '0;
  logic            rst_done = 1'b0;
  logic            rst_req;
  logic            irq;

  int nchk = 0;
  int nfail = 0;
  bit finished = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #CLK_HALF clk = ~clk;

  hc_cmd_irq_regs #(.NEVT(NEVT)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_code(cmd_code), .wr_data(wr_data),
    .wr_stb(wr_stb), .rd_stb(rd_stb), .rd_data(rd_data), .evt(evt),
    .rst_done(rst_done), .rst_req(rst_req), .irq(irq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  endtask

  always begin
    @(posedge clk);
    if (rst_n && rd_stb) begin
      @(negedge clk);
      if (exp_q.size() == 0) check("scoreboard", 32'd1, 32'd0);
      else check(tag_q.pop_front(), rd_data, exp_q.pop_front());
    end
  end

  task automatic wr(logic [7:0] code, logic [31:0] data, logic [NEVT-1:0] ev = '0);
    cmd_code = code; wr_data = data; wr_stb = 1'b1; evt = ev;
    @(negedge clk);
    wr_stb = 1'b0; evt = '0;
  endtask

  task automatic rd(logic [7:0] code, logic [31:0] exp, string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    cmd_code = code; rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  task automatic pulse(logic [NEVT-1:0] ev);
    evt = ev;
    @(negedge clk);
    evt = '0;
  endtask

  initial begin
    #(CLK_HALF * 2 * 200000);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 irq", {31'b0, irq}, 32'd0);
    check("R1 rst_req", {31'b0, rst_req}, 32'd0);
    check("R1 rd_data", rd_data, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    rd(8'h02, 32'h0, "R1 cs");
    rd(8'h03, 32'h0, "R1 is");
    rd(8'h04, 32'h0, "R1 ie");

    pulse(7'h01);
    rd(8'h02, 32'h0001_0000, "R3 count one");
    rd(8'h03, 32'h1, "R7 ovr flag");
    pulse(7'h01);
    pulse(7'h01);
    rd(8'h02, 32'h0003_0000, "R4 count while flag set");
    pulse(7'h01);
    rd(8'h02, 32'h0, "R3 wrap");

    wr(8'h83, 32'h0);
    rd(8'h03, 32'h1, "R8 zero write keeps");
    wr(8'h83, 32'h1);
    rd(8'h03, 32'h0, "R8 one clears");
    wr(8'h83, 32'hFFFF_FFFF);
    rd(8'h03, 32'h0, "R8 no sw set");

    pulse(7'h2A);
    rd(8'h03, 32'h2A, "R7 multi event");
    wr(8'h83, 32'h02, 7'h02);
    rd(8'h03, 32'h2A, "R9 set wins");
    wr(8'h83, 32'h0A, 7'h02);
    rd(8'h03, 32'h22, "R9 neighbour clear");

    check("R10 no enable", {31'b0, irq}, 32'd0);
    wr(8'h84, 32'h0000_0002);
    check("R10 no master", {31'b0, irq}, 32'd0);
    rd(8'h04, 32'h0000_0002, "R10 ie read");
    wr(8'h84, 32'h8000_0002);
    check("R10 fire", {31'b0, irq}, 32'd1);
    wr(8'h84, 32'h8000_0001);
    check("R10 unmatched enable", {31'b0, irq}, 32'd0);
    wr(8'h84, 32'h8000_0020);
    check("R10 bit5", {31'b0, irq}, 32'd1);
    wr(8'h83, 32'h20);
    check("R10 cleared", {31'b0, irq}, 32'd0);

    wr(8'h85, 32'hFFFF_FFFF);
    wr(8'h03, 32'hFFFF_FFFF);
    rd(8'h03, 32'h02, "R11 is untouched");
    rd(8'h04, 32'h8000_0020, "R11 ie untouched");
    rd(8'h10, 32'h0, "R11 unknown read");
    wr(8'h82, 32'hFFFF_FFFE);
    check("R5 bit0 zero", {31'b0, rst_req}, 32'd0);
    pulse(7'h01);
    rd(8'h02, 32'h0001_0000, "R2 reserved zero");

    rst_done = 1'b1;
    @(negedge clk);
    rst_done = 1'b0;
    check("R5 done idle", {31'b0, rst_req}, 32'd0);

    wr(8'h82, 32'h1);
    check("R5 req", {31'b0, rst_req}, 32'd1);
    check("R6 irq", {31'b0, irq}, 32'd0);
    rd(8'h02, 32'h1, "R6 cs cleared");
    rd(8'h03, 32'h0, "R6 is cleared");
    rd(8'h04, 32'h0, "R6 ie cleared");
    pulse(7'h7F);
    wr(8'h84, 32'h8000_0001);
    rd(8'h03, 32'h0, "R6 events ignored");
    rd(8'h02, 32'h1, "R6 count held");
    rd(8'h04, 32'h0, "R6 ie held");
    wr(8'h82, 32'h0);
    check("R5 sticky", {31'b0, rst_req}, 32'd1);
    rst_done = 1'b1;
    @(negedge clk);
    rst_done = 1'b0;
    check("R5 release", {31'b0, rst_req}, 32'd0);
    rd(8'h02, 32'h0, "R5 cs after");
    pulse(7'h01);
    rd(8'h02, 32'h0001_0000, "R3 count after reset");
    rd(8'h03, 32'h1, "R7 event after reset");

    repeat (3) @(negedge clk);
    check("scoreboard drained", exp_q.size(), 32'd0);
    finish_run();
  end
endmodule